// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This unit decides whether a conditional branch will be taken. While the branch sits in the decode stage, the unit tests its 4-bit condition code against the zero, negative, carry-out and overflow flags. Those flags come from the instruction one step ahead in execute, which is always an add, a subtract or an add-immediate when a branch follows it. The decision is made late in decode and held in a flip-flop. When the pipeline advances, the branch enters execute and the unit raises a taken strobe for that stage.

Along with the decision, the unit captures the branch displacement. It sign-extends the 8-bit field to the PC width and multiplies it by two. The PC incrementer then adds this value to the PC when the strobe is high. Both registered outputs change only on cycles where the pipeline clock enable is high, and both clear on reset.

Top module: `branch_cond_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, br_taken is 0 and br_offset is 0.
- R2: On a rising edge with pipe_adv high, br_taken becomes 1 exactly when dc_branch is 1, dc_annul is 0 and the selected condition is true.
- R3: An annulled branch (dc_annul high) never sets br_taken, whatever its condition and flags.
- R4: A decode instruction that is not a branch (dc_branch low) leaves br_taken at 0 after an advance.
- R5: On an edge with pipe_adv low, br_taken and br_offset keep their values even when every other input changes.
- R6: Flag conditions, by cond value: 0 always, 1 never, 2 Z set, 3 Z clear, 4 CO set, 5 CO clear, 6 N set, 7 N clear, 8 V set, 9 V clear.
- R7: Signed comparisons of a subtraction a-b: 10 less (N xor V), 11 greater-or-equal, 12 less-or-equal (Z or (N xor V)), 13 greater.
- R8: Unsigned comparisons, where CO high means no borrow: 14 lower-or-same (CO clear or Z set), 15 higher (CO set and Z clear). Codes 5 and 4 serve as unsigned lower and higher-or-same.
- R9: On an advance, br_offset takes the 8-bit disp sign-extended to PC_W bits and shifted left by one, so bit 0 is always 0.
- R10: For any flag values, an odd cond value selects the complement of the outcome of the even value just below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_adv | input | 1 | Pipeline clock enable; the stage registers update when it is high |
| dc_branch | input | 1 | The decode instruction is a conditional branch |
| dc_annul | input | 1 | The decode instruction is annulled |
| dc_cond | input | 4 | Condition code of the branch |
| ex_z | input | 1 | Zero flag of the execute instruction |
| ex_n | input | 1 | Negative flag of the execute instruction |
| ex_co | input | 1 | Carry-out flag of the execute instruction |
| ex_v | input | 1 | Overflow flag of the execute instruction |
| dc_disp | input | 8 | Signed branch displacement, counted in halfword units |
| br_taken | output | 1 | Taken strobe, high while a taken branch is in execute |
| br_offset | output | PC_W | Byte offset to add to the PC |

## Verification
The hardest condition codes to exercise properly are the signed and unsigned comparisons. They rely on combinations of flag values that only arise from particular subtractions. One example is overflow with a non-negative result, where a signed "less" must still come out true. The stimulus therefore produces the flags from real 16-bit subtractions of operand pairs chosen near the sign and carry boundaries. Each outcome is then checked against a direct comparison of those operands. A separate exhaustive sweep of all 16 codes over all 16 flag combinations covers the flag-only codes and the complement pairing.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int COND_W = 4;

    // Condition codes; odd codes complement the even code below them
    typedef enum logic [COND_W-1:0] {
        C_ALWAYS = 4'd0,  C_NEVER = 4'd1,
        C_ZS     = 4'd2,  C_ZC    = 4'd3,
        C_CS     = 4'd4,  C_CC    = 4'd5,
        C_NS     = 4'd6,  C_NC    = 4'd7,
        C_VS     = 4'd8,  C_VC    = 4'd9,
        C_SLT    = 4'd10, C_SGE   = 4'd11,
        C_SLE    = 4'd12, C_SGT   = 4'd13,
        C_ULS    = 4'd14, C_UHI   = 4'd15
    } cond_e;

    typedef struct packed {
        logic z;
        logic n;
        logic co;
        logic v;
    } flags_t;

endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flags,
    output logic              cond_true
);

    localparam int N_BASE = 2 ** (COND_W - 1);

    logic [N_BASE-1:0] base;
    logic              lt_signed;

    always_comb begin
        lt_signed = flags.n ^ flags.v;
        base      = '0;
        base[0]   = 1'b1;
        base[1]   = flags.z;
        base[2]   = flags.co;
        base[3]   = flags.n;
        base[4]   = flags.v;
        base[5]   = lt_signed;
        base[6]   = flags.z | lt_signed;
        base[7]   = ~flags.co | flags.z;
    end

    // The upper code bits pick a base test, the low bit inverts it
    assign cond_true = base[cond[COND_W-1:1]] ^ cond[0];

endmodule

// File: rtl/bcu_disp_scale.sv
module bcu_disp_scale #(
    parameter int DISP_W = 8,
    parameter int OUT_W  = 16,
    parameter int SHIFT  = 1
) (
    input  logic [DISP_W-1:0] disp,
    output logic [OUT_W-1:0]  offset
);

    localparam int EXT_W = OUT_W - DISP_W - SHIFT;

    generate
        if (SHIFT == 0) begin : g_noshift
            assign offset = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_shift
            assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {SHIFT{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_adv,
    input  logic              dc_branch,
    input  logic              dc_annul,
    input  logic [COND_W-1:0] dc_cond,
    input  logic              ex_z,
    input  logic              ex_n,
    input  logic              ex_co,
    input  logic              ex_v,
    input  logic [DISP_W-1:0] dc_disp,
    output logic              br_taken,
    output logic [PC_W-1:0]   br_offset
);

    localparam int DISP_SHIFT = 1;

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] offset;
    } state_t;

    state_t          st_d, st_q;
    flags_t          flags;
    logic            cond_true;
    logic [PC_W-1:0] scaled;

    assign flags = '{z: ex_z, n: ex_n, co: ex_co, v: ex_v};

    bcu_cond_eval u_eval (
        .cond      (dc_cond),
        .flags     (flags),
        .cond_true (cond_true)
    );

    bcu_disp_scale #(
        .DISP_W (DISP_W),
        .OUT_W  (PC_W),
        .SHIFT  (DISP_SHIFT)
    ) u_scale (
        .disp   (dc_disp),
        .offset (scaled)
    );

    always_comb begin
        st_d = st_q;
        if (pipe_adv) begin
            st_d.taken  = dc_branch & ~dc_annul & cond_true;
            st_d.offset = scaled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign br_taken  = st_q.taken;
    assign br_offset = st_q.offset;

endmodule

// File: rtl/branch_cond_unit_checker.sv
module branch_cond_unit_checker #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_adv,
    input logic              dc_branch,
    input logic              dc_annul,
    input logic [3:0]        dc_cond,
    input logic [DISP_W-1:0] dc_disp,
    input logic              br_taken,
    input logic [PC_W-1:0]   br_offset
);

    a_r3_annul_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_adv && dc_annul |=> !br_taken);

    a_r4_non_branch: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_adv && !dc_branch |=> !br_taken);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_adv |=> $stable(br_taken) && $stable(br_offset));

    a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_adv && dc_branch && !dc_annul && dc_cond == 4'd0 |=> br_taken);

    a_r6_never: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_adv && dc_cond == 4'd1 |=> !br_taken);

    a_r9_even: assert property (@(posedge clk) disable iff (!rst_n)
        br_offset[0] == 1'b0);

    a_r9_sign: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_adv |=> br_offset[PC_W-1] == $past(dc_disp[DISP_W-1]));

endmodule

bind branch_cond_unit branch_cond_unit_checker #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_adv  (pipe_adv),
    .dc_branch (dc_branch),
    .dc_annul  (dc_annul),
    .dc_cond   (dc_cond),
    .dc_disp   (dc_disp),
    .br_taken  (br_taken),
    .br_offset (br_offset)
);

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pipe_adv = 1'b0;
    logic            dc_branch = 1'b0;
    logic            dc_annul = 1'b0;
    logic [3:0]      dc_cond = '0;
    logic            ex_z = 1'b0, ex_n = 1'b0, ex_co = 1'b0, ex_v = 1'b0;
    logic [7:0]      dc_disp = '0;
    logic            br_taken;
    logic [PC_W-1:0] br_offset;

    int checks = 0;
    int failures = 0;

    logic [PC_W:0] q_exp[$];
    string         q_tag[$];

    logic            m_taken = 1'b0;
    logic [PC_W-1:0] m_off = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_cond_unit #(.PC_W(PC_W), .DISP_W(8)) i_branch_cond_unit (
        .clk(clk), .rst_n(rst_n), .pipe_adv(pipe_adv),
        .dc_branch(dc_branch), .dc_annul(dc_annul), .dc_cond(dc_cond),
        .ex_z(ex_z), .ex_n(ex_n), .ex_co(ex_co), .ex_v(ex_v),
        .dc_disp(dc_disp), .br_taken(br_taken), .br_offset(br_offset)
    );

    // Condition table from R6, R7, R8
    function automatic logic ref_cond(input logic [3:0] c, input logic z, n, co, v);
        case (c)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return z;
            4'd3:  return !z;
            4'd4:  return co;
            4'd5:  return !co;
            4'd6:  return n;
            4'd7:  return !n;
            4'd8:  return v;
            4'd9:  return !v;
            4'd10: return n != v;
            4'd11: return n == v;
            4'd12: return z || (n != v);
            4'd13: return !z && (n == v);
            4'd14: return !co || z;
            default: return co && !z;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [PC_W:0] act, input logic [PC_W:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected outputs
    task automatic drive(input logic adv, br, an, input logic [3:0] c,
                         input logic z, n, co, v, input logic [7:0] d,
                         input logic exp_override, exp_val, input string tag);
        @(negedge clk);
        pipe_adv = adv; dc_branch = br; dc_annul = an; dc_cond = c;
        ex_z = z; ex_n = n; ex_co = co; ex_v = v; dc_disp = d;
        if (adv) begin
            m_taken = exp_override ? exp_val : (br && !an && ref_cond(c, z, n, co, v));
            m_off   = {{(PC_W-9){d[7]}}, d, 1'b0};
        end
        q_exp.push_back({m_taken, m_off});
        q_tag.push_back(tag);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_exp.size() > 0) begin
                logic [PC_W:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check({br_taken, br_offset} === e, t, {br_taken, br_offset}, e);
            end
        end
    end

    task automatic sub_case(input logic [15:0] a, b);
        logic [16:0] s;
        logic z, n, co, v;
        s  = {1'b0, a} + {1'b0, ~b} + 17'd1;
        co = s[16];
        z  = (s[15:0] == 16'd0);
        n  = s[15];
        v  = (a[15] != b[15]) && (s[15] != a[15]);
        drive(1, 1, 0, 4'd10, z, n, co, v, 8'h01, 1, $signed(a) <  $signed(b), "R7_slt");
        drive(1, 1, 0, 4'd11, z, n, co, v, 8'h02, 1, $signed(a) >= $signed(b), "R7_sge");
        drive(1, 1, 0, 4'd12, z, n, co, v, 8'h03, 1, $signed(a) <= $signed(b), "R7_sle");
        drive(1, 1, 0, 4'd13, z, n, co, v, 8'h04, 1, $signed(a) >  $signed(b), "R7_sgt");
        drive(1, 1, 0, 4'd14, z, n, co, v, 8'h05, 1, a <= b, "R8_uls");
        drive(1, 1, 0, 4'd15, z, n, co, v, 8'h06, 1, a >  b, "R8_uhi");
        drive(1, 1, 0, 4'd5,  z, n, co, v, 8'h07, 1, a <  b, "R8_ulo");
        drive(1, 1, 0, 4'd4,  z, n, co, v, 8'h08, 1, a >= b, "R8_uhs");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        pipe_adv = 1'b1; dc_branch = 1'b1; dc_cond = 4'd0; dc_disp = 8'h7F;
        repeat (3) @(negedge clk);
        check({br_taken, br_offset} === '0, "R1_reset", {br_taken, br_offset}, '0);
        rst_n = 1'b1;
        pipe_adv = 1'b0;

        // R6 R7 R8 R10: every code against every flag combination
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive(1, 1, 0, c[3:0], f[3], f[2], f[1], f[0], 8'(c * 16 + f), 0, 0,
                      (c % 2 == 1) ? "R10_odd_code" : "R6_R7_R8_code");
            end
        end

        // R7 R8 with flags from real subtractions near the boundaries
        sub_case(16'h0005, 16'h0005);
        sub_case(16'h0003, 16'h0009);
        sub_case(16'h8000, 16'h0001);
        sub_case(16'h7FFF, 16'hFFFF);
        sub_case(16'hFFFF, 16'h0001);
        sub_case(16'h0001, 16'h8000);

        // R3: annulled branches with always-true conditions
        drive(1, 1, 1, 4'd0, 0, 0, 0, 0, 8'h10, 1, 0, "R3_annul_always");
        drive(1, 1, 1, 4'd2, 1, 0, 0, 0, 8'h11, 1, 0, "R3_annul_eq");
        // R4: non-branch instruction
        drive(1, 1, 0, 4'd0, 0, 0, 0, 0, 8'h12, 1, 1, "R2_taken");
        drive(1, 0, 0, 4'd0, 0, 0, 0, 0, 8'h13, 1, 0, "R4_non_branch");
        drive(1, 0, 1, 4'd11, 0, 0, 0, 0, 8'h14, 1, 0, "R4_non_branch_annul");

        // R5: hold with pipe_adv low while inputs change
        drive(1, 1, 0, 4'd0, 0, 0, 0, 0, 8'h85, 1, 1, "R2_taken_before_hold");
        drive(0, 0, 1, 4'd1, 1, 1, 1, 1, 8'h22, 0, 0, "R5_hold_a");
        drive(0, 1, 0, 4'd3, 1, 0, 0, 0, 8'h7E, 0, 0, "R5_hold_b");
        drive(1, 1, 0, 4'd1, 0, 0, 0, 0, 8'h00, 1, 0, "R2_not_taken");
        drive(0, 1, 0, 4'd0, 0, 0, 0, 0, 8'hFF, 0, 0, "R5_hold_c");

        // R9: displacement boundaries
        drive(1, 1, 0, 4'd0, 0, 0, 0, 0, 8'h7F, 1, 1, "R9_max_pos");
        drive(1, 1, 0, 4'd0, 0, 0, 0, 0, 8'h80, 1, 1, "R9_max_neg");
        drive(1, 1, 0, 4'd0, 0, 0, 0, 0, 8'hFF, 1, 1, "R9_minus_one");
        drive(1, 1, 0, 4'd0, 0, 0, 0, 0, 8'h00, 1, 1, "R9_zero");
        drive(0, 0, 0, 4'd0, 0, 0, 0, 0, 8'h00, 0, 0, "R5_final");

        while (q_exp.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule